// File: doc/BRIEF.md
# GPIO Data Register Port

This block is the data side of a 32-pin general-purpose I/O port. A simple word-addressed register bus reaches an output latch, a direction register and the sampled pin levels. Three write-only alias registers sit next to the latch. They set, clear or invert only the latch bits whose mask bit is one. Software can therefore change single pins without a read-modify-write sequence, and no lock is needed between agents that share the port.

Each pad is modelled by two bits. One is an output enable, taken from the direction bit. The other is an output value, taken from the latch bit. Input levels pass through a two-stage synchronizer before software can read them. For a pin it drives, software reads the latch and not the input register. Pin multiplexing, filtering and interrupt logic are outside this block.

Top module: `gpio_dp_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the latch and direction clear after that edge. `pin_out`, `pin_oe` and `bus_rvalid` are then all zero.
- R2: A write at byte offset 0x00 loads the latch with `bus_wdata`. `pin_out` shows the new value after that edge, and a read at 0x00 returns the latch.
- R3: A write at 0x04 ORs `bus_wdata` into the latch. Latch bits under zero mask bits keep their value.
- R4: A write at 0x08 clears each latch bit whose `bus_wdata` bit is one. All other latch bits keep their value.
- R5: A write at 0x0C inverts each latch bit whose `bus_wdata` bit is one. All other latch bits keep their value.
- R6: A write at 0x14 loads the direction register. A one makes the pin an output and a zero makes it an input. `pin_oe` equals the direction register, and a read at 0x14 returns it.
- R7: A read at 0x10 returns `pin_in` after a two-flop synchronizer. A pin change made just before edge k is seen by reads captured at edge k+2 or later, but not by a read captured at edge k.
- R8: Reads at 0x04, 0x08 and 0x0C return zero.
- R9: Writes at 0x10, at any offset above 0x14, or at any address whose bits [1:0] are not zero leave the latch and direction unchanged. Reads at those addresses return zero.
- R10: A read captured at one clock edge raises `bus_rvalid` for exactly the following cycle, with `bus_rdata` valid. Back-to-back reads give back-to-back results, and `bus_rdata` is zero while `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data / mask |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read result valid (one cycle after the read) |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_oe | output | 32 | Pad output enables |
| pin_out | output | 32 | Pad output values |

## Verification
The latch is loaded with patterns whose set bits partly overlap the masks used afterwards. This shows that set, clear and toggle each touch only the masked bits and use the right operation: an OR, a clear or an invert. The same toggle mask is applied twice to tell an invert from a one-shot set. The input register is read once right after a pin change and again three cycles later, which shows both the two-stage delay and that the synchronizer is present. The misaligned, reserved and input-register addresses are hit with writes of all ones; the latch and direction stay unchanged, which tells a correct decoder from one that aliases those addresses onto a writable register.

// File: rtl/gpio_dp_pkg.sv
// Shared definitions for the GPIO data register port.
// Assumes a word-aligned byte address bus; word index sits in address bits [4:2].
package gpio_dp_pkg;

    // Word index of each register; the order fixes the byte offsets.
    typedef enum logic [2:0] {
        IDX_DATA = 3'd0,
        IDX_SET  = 3'd1,
        IDX_CLR  = 3'd2,
        IDX_TOG  = 3'd3,
        IDX_IN   = 3'd4,
        IDX_DIR  = 3'd5
    } reg_idx_e;

    // Decoded access for one cycle.
    typedef struct packed {
        logic     wr_data;
        logic     wr_set;
        logic     wr_clr;
        logic     wr_tog;
        logic     wr_dir;
        logic     rd;
        logic     hit;
        reg_idx_e idx;
    } access_t;

endpackage

// File: rtl/gpio_dp_decode.sv
// Address decoder: turns one bus request into register strobes.
// Assumes addr is a byte address; non-aligned or out-of-map addresses decode as no hit.
module gpio_dp_decode
    import gpio_dp_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    output access_t       acc
);
    localparam int unsigned IDX_W = 3;
    localparam int unsigned HI_LSB = IDX_W + 2;

    logic [IDX_W-1:0] idx_raw;
    logic             upper_zero;
    logic             in_map;

    // Split the address and test for a defined register.
    always_comb begin
        idx_raw    = bus_addr[HI_LSB-1:2];
        upper_zero = (bus_addr[AW-1:HI_LSB] == '0) && (bus_addr[1:0] == 2'b00);
        in_map     = upper_zero && (idx_raw <= IDX_DIR);
    end

    // Produce write strobes and read request.
    always_comb begin
        acc         = '0;
        acc.idx     = reg_idx_e'(idx_raw);
        acc.hit     = in_map;
        acc.rd      = bus_en && !bus_we;
        if (bus_en && bus_we && in_map) begin
            unique case (reg_idx_e'(idx_raw))
                IDX_DATA: acc.wr_data = 1'b1;
                IDX_SET:  acc.wr_set  = 1'b1;
                IDX_CLR:  acc.wr_clr  = 1'b1;
                IDX_TOG:  acc.wr_tog  = 1'b1;
                IDX_DIR:  acc.wr_dir  = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_dp_regs.sv
// Output latch and direction register with atomic set/clear/toggle updates.
// Assumes at most one strobe in acc is active per cycle (guaranteed by the decoder).
module gpio_dp_regs
    import gpio_dp_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  access_t      acc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] latch_d;

    // Next latch value for the active update kind.
    always_comb begin
        latch_d = latch_q;
        if (acc.wr_data)     latch_d = wdata;
        else if (acc.wr_set) latch_d = latch_q | wdata;
        else if (acc.wr_clr) latch_d = latch_q & ~wdata;
        else if (acc.wr_tog) latch_d = latch_q ^ wdata;
    end

    // Latch storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // Direction storage, cleared by reset so all pins start as inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_q <= '0;
        else if (acc.wr_dir) dir_q <= wdata;
    end

endmodule

// File: rtl/gpio_dp_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no bus coherence across bits is promised.
module gpio_dp_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // Shift the pad levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_dp_rdport.sv
// Registered read multiplexer: one-cycle read latency, zero data when idle.
// Assumes acc.hit is low for any reserved or misaligned address.
module gpio_dp_rdport
    import gpio_dp_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  access_t      acc,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pins_sync,
    output logic [W-1:0] rdata,
    output logic         rvalid
);
    logic [W-1:0] mux;

    // Select the register addressed by the read.
    always_comb begin
        mux = '0;
        if (acc.hit) begin
            case (acc.idx)
                IDX_DATA: mux = latch_q;
                IDX_IN:   mux = pins_sync;
                IDX_DIR:  mux = dir_q;
                default:  mux = '0;
            endcase
        end
    end

    // Capture the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= acc.rd;
            rdata  <= acc.rd ? mux : '0;
        end
    end

endmodule

// File: rtl/gpio_dp_top.sv
// GPIO data register port: output latch, set/clear/toggle aliases, direction,
// synchronized input sampling. Assumes a single bus master, one access per cycle.
module gpio_dp_top
    import gpio_dp_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned AW     = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          bus_rvalid,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_out
);
    access_t      acc;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pins_sync;

    gpio_dp_decode #(.AW(AW)) u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    gpio_dp_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_dp_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    gpio_dp_rdport #(.W(W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    // Pad drive follows the registers directly.
    always_comb begin
        pin_oe  = dir_q;
        pin_out = latch_q;
    end

endmodule

// File: rtl/gpio_dp_chk.sv
// Property checker for gpio_dp_top, attached by bind. Observes ports only.
module gpio_dp_chk #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic          bus_rvalid,
    input logic [W-1:0]  pin_oe,
    input logic [W-1:0]  pin_out
);
    logic wr, rd;
    always_comb begin
        wr = bus_en && bus_we;
        rd = bus_en && !bus_we;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !bus_rvalid));

    a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h00) |=> pin_out == $past(bus_wdata));

    a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h04) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h08) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    a_r5_tog_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h0C) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

    a_r6_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h14) |=> pin_oe == $past(bus_wdata));

    a_r8_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (bus_addr == 8'h04 || bus_addr == 8'h08 || bus_addr == 8'h0C))
        |=> bus_rdata == '0);

    a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_addr == 8'h10 || bus_addr > 8'h14 || bus_addr[1:0] != 2'b00))
        |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);

    a_r10_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (!bus_rvalid && bus_rdata == '0));

endmodule

bind gpio_dp_top gpio_dp_chk #(.W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
);

// File: tb/tb_gpio_dp_top.sv
module tb_gpio_dp_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int AW = 8;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          bus_rvalid;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_oe;
    logic [W-1:0]  pin_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];
    logic [W-1:0] m_out = '0;
    logic [W-1:0] m_dir = '0;

    gpio_dp_top dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        sb.push_back('{val: exp, tag: tag});
    endtask

    task automatic idle();
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic pads(input string tag);
        check({tag, " pin_out"}, pin_out, m_out);
        check({tag, " pin_oe"}, pin_oe, m_dir);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops expected read results as the design returns them.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10 unexpected rvalid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " read"}, bus_rdata, e.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 rvalid", {31'b0, bus_rvalid}, '0);
        rst_n = 1'b1;
        rd(8'h00, 32'h0, "R1");
        rd(8'h14, 32'h0, "R1");
        idle();

        // R2: direct load
        m_out = 32'hA5A5_0F0F;
        wr(8'h00, m_out); idle(); pads("R2");
        rd(8'h00, m_out, "R2"); idle();

        // R3: set alias
        wr(8'h04, 32'h0000_F0F0); idle();
        m_out = m_out | 32'h0000_F0F0; pads("R3");
        rd(8'h00, m_out, "R3"); idle();

        // R4: clear alias
        wr(8'h08, 32'h0F00_00FF); idle();
        m_out = m_out & ~32'h0F00_00FF; pads("R4");
        rd(8'h00, m_out, "R4"); idle();

        // R5: toggle alias twice
        wr(8'h0C, 32'hFFFF_0000); idle();
        m_out = m_out ^ 32'hFFFF_0000; pads("R5");
        wr(8'h0C, 32'h00FF_FF00); idle();
        m_out = m_out ^ 32'h00FF_FF00; pads("R5");
        rd(8'h00, m_out, "R5"); idle();

        // R6: direction
        m_dir = 32'h00FF_00FF;
        wr(8'h14, m_dir); idle(); pads("R6");
        rd(8'h14, m_dir, "R6");
        rd(8'h00, m_out, "R6"); idle();

        // R8: aliases read zero
        rd(8'h04, 32'h0, "R8");
        rd(8'h08, 32'h0, "R8");
        rd(8'h0C, 32'h0, "R8"); idle();

        // R7: synchronizer delay
        @(negedge clk);
        pin_in = 32'h1234_5678;
        rd(8'h10, 32'h0, "R7 early"); idle();
        repeat (2) @(negedge clk);
        rd(8'h10, 32'h1234_5678, "R7 settled"); idle();
        @(negedge clk);
        pin_in = 32'hCAFE_0001;
        repeat (3) @(negedge clk);
        rd(8'h10, 32'hCAFE_0001, "R7 second"); idle();

        // R9: ignored writes and reserved reads
        wr(8'h10, 32'hFFFF_FFFF); idle(); pads("R9 in-reg write");
        wr(8'h18, 32'hFFFF_FFFF); idle(); pads("R9 reserved write");
        wr(8'h40, 32'hFFFF_FFFF); idle(); pads("R9 high write");
        wr(8'h05, 32'hFFFF_FFFF); idle(); pads("R9 misaligned set");
        wr(8'h15, 32'hFFFF_FFFF); idle(); pads("R9 misaligned dir");
        rd(8'h10, 32'hCAFE_0001, "R9 input kept");
        rd(8'h18, 32'h0, "R9");
        rd(8'h80, 32'h0, "R9");
        rd(8'h01, 32'h0, "R9"); idle();

        // R10: back-to-back reads, then idle zero data
        rd(8'h00, m_out, "R10");
        rd(8'h14, m_dir, "R10");
        rd(8'h10, 32'hCAFE_0001, "R10"); idle();
        repeat (3) @(negedge clk);
        check("R10 idle rvalid", {31'b0, bus_rvalid}, '0);
        check("R10 idle rdata", bus_rdata, '0);
        check("R10 queue drained", sb.size(), 0);

        done = 1'b1;
        report();
    end

endmodule